// File: doc/BRIEF.md
# Configuration Request Router

The router accepts one configuration access at a time from a host-side request port and decides where it goes. A request carries a bus number, a device/function byte, a 12-bit register offset, an access size in bytes, a write flag and write data. Three outcomes are possible. On bus 0 the access is served by the emulated bridge header of the port whose assigned device/function matches. On any other bus the access is forwarded over that port's downstream link. Otherwise the access is answered locally as "no device".

For forwarded accesses the router builds the indirect configuration-address word. It places sub-word write data on the correct byte lanes with byte enables, and it shifts and masks returned read data. A single downstream channel serves both the bridge headers and the links. A flag on that channel says which kind of target it is, and a port index says which port. Only one access is in flight at a time. `req_ready_o` stays low from acceptance until the one-cycle response has been issued.

Top module: `cfg_router`

## Requirements
- R1: On bus 0 the request goes to the bridge header (`dn_bridge_o`=1) of the lowest-index port whose `port_devfn_i` byte equals `req_devfn_i`. The link state is ignored. `dn_addr_o` is the dword offset {20'b0, offset[11:2], 2'b00}.
- R2: On a nonzero bus the lowest-index port with secondary ≤ bus ≤ subordinate is selected and the access goes to its link (`dn_bridge_o`=0). If no port matches, the status is "no device" (2'b01) and the read data are 32'hFFFFFFFF.
- R3: If the selected port's `port_link_up_i` bit is 0, a nonzero-bus request ends with status 2'b01, all-ones data and no downstream access.
- R4: When the bus equals the selected port's secondary bus, a device number (devfn[7:3]) other than 0 gives status 2'b01 and all ones. Buses above the secondary bus within the range pass any device.
- R5: The link address word is {1'b1, 3'b000, offset[11:8], bus[7:0], devfn[7:3], devfn[2:0], offset[7:2], 2'b00}, with bit 31 set.
- R6: Read data returned on `dn_rdata_i` are shifted right by 8×offset[1:0]. Size 1 keeps 8 bits and size 2 keeps 16 bits. Size 4 returns the whole word unshifted.
- R7: Writes use byte enables 4'b0001<<offset[1:0] for size 1, 4'b0011<<offset[1:0] truncated to 4 bits for size 2, and 4'b1111 for size 4. `dn_wdata_o` is the zero-extended data shifted left by 8×offset[1:0] for sub-word sizes. A completed write returns data 0 with status 2'b00.
- R8: A size other than 1, 2 or 4 gives status 2'b10 with all-ones data and no downstream access. A "no device" outcome takes precedence over this check.
- R9: `req_ready_o` is low from acceptance until after the response. `rsp_valid_o` is a one-cycle pulse, one per request. `dn_req_o` and its fields stay stable until the cycle in which `dn_ack_i` is high.
- R10: After reset `req_ready_o` is 1 and `rsp_valid_o` and `dn_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Router idle, request accepted when valid |
| req_bus_i | input | 8 | Bus number |
| req_devfn_i | input | 8 | Device [7:3] and function [2:0] |
| req_off_i | input | 12 | Register byte offset |
| req_size_i | input | 3 | Access size in bytes |
| req_we_i | input | 1 | 1 = write |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_status_o | output | 2 | 00 ok, 01 no device, 10 bad register |
| rsp_rdata_o | output | 32 | Read data |
| port_devfn_i | input | 8×N_PORTS | Per-port device/function on bus 0 |
| port_sec_bus_i | input | 8×N_PORTS | Per-port secondary bus |
| port_sub_bus_i | input | 8×N_PORTS | Per-port subordinate bus |
| port_link_up_i | input | N_PORTS | Per-port link state |
| dn_req_o | output | 1 | Downstream access pending |
| dn_bridge_o | output | 1 | 1 = bridge header, 0 = link |
| dn_port_o | output | PORT_W | Selected port |
| dn_we_o | output | 1 | Downstream write |
| dn_addr_o | output | 32 | Dword offset or address word |
| dn_be_o | output | 4 | Byte enables |
| dn_wdata_o | output | 32 | Lane-aligned write data |
| dn_ack_i | input | 1 | Downstream completion |
| dn_rdata_i | input | 32 | Downstream read word |

## Verification
Overlapping bus ranges check priority: a bus claimed by two ports must reach the lower index even when that port's link is down. A router that kept searching would forward the access over the wrong port. Bus 0 is probed with a duplicated device/function byte and with an unknown one. A bad size is sent to an unmatched bus to show that "no device" wins, where a wrong order would report 2'b10. Sub-word reads and writes at offsets 1, 2 and 3 expose wrong shift amounts or byte enables, and size 2 at lane 3 exposes a missing 4-bit truncation. Requests on the secondary bus with nonzero and zero device numbers separate the slot filter from the subordinate-bus pass-through.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;
  localparam int BUS_W  = 8;
  localparam int OFF_W  = 12;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_OK     = 2'b00,
    ST_NODEV  = 2'b01,
    ST_BADREG = 2'b10
  } cfg_status_e;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_BRIDGE = 2'd1,
    TGT_LINK   = 2'd2
  } cfg_target_e;

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction
endpackage

// File: rtl/cfg_port_select.sv
module cfg_port_select
  import cfg_router_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int PORT_W  = 2
) (
  input  logic [BUS_W-1:0]         bus_i,
  input  logic [7:0]               devfn_i,
  input  logic [N_PORTS*8-1:0]     port_devfn_i,
  input  logic [N_PORTS*BUS_W-1:0] sec_bus_i,
  input  logic [N_PORTS*BUS_W-1:0] sub_bus_i,
  input  logic [N_PORTS-1:0]       link_up_i,
  output logic [PORT_W-1:0]        port_o,
  output cfg_target_e              target_o
);
  logic [N_PORTS-1:0] fn_hit, rng_hit, on_sec, hit;
  logic               found, root_bus;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    logic [BUS_W-1:0] sec, sub;
    assign sec        = sec_bus_i[i*BUS_W +: BUS_W];
    assign sub        = sub_bus_i[i*BUS_W +: BUS_W];
    assign fn_hit[i]  = port_devfn_i[i*8 +: 8] == devfn_i;
    assign rng_hit[i] = (bus_i >= sec) && (bus_i <= sub);
    assign on_sec[i]  = bus_i == sec;
  end

  assign root_bus = bus_i == '0;
  assign hit      = root_bus ? fn_hit : rng_hit;

  // lowest index wins: scan downward, last hit kept
  always_comb begin
    found  = 1'b0;
    port_o = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found  = 1'b1;
        port_o = PORT_W'(i);
      end
    end
  end

  always_comb begin
    if (!found)                                   target_o = TGT_NONE;
    else if (root_bus)                            target_o = TGT_BRIDGE;
    else if (!link_up_i[port_o])                  target_o = TGT_NONE;
    else if (on_sec[port_o] && devfn_i[7:3] != 0) target_o = TGT_NONE;
    else                                          target_o = TGT_LINK;
  end
endmodule

// File: rtl/cfg_addr_fmt.sv
module cfg_addr_fmt
  import cfg_router_pkg::*;
(
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [7:0]        devfn_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              bridge_i,
  output logic [WORD_W-1:0] addr_o
);
  logic [WORD_W-1:0] conf_word, dword_off;

  assign conf_word = {1'b1, 3'b000, off_i[11:8], bus_i, devfn_i[7:3], devfn_i[2:0],
                      off_i[7:2], 2'b00};
  assign dword_off = {{(WORD_W-OFF_W){1'b0}}, off_i[11:2], 2'b00};
  assign addr_o    = bridge_i ? dword_off : conf_word;
endmodule

// File: rtl/cfg_lane_align.sv
module cfg_lane_align
  import cfg_router_pkg::*;
(
  input  logic [1:0]        lane_i,
  input  logic [2:0]        size_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] rdata_raw_i,
  output logic [3:0]        be_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic [4:0]        sh;
  logic [WORD_W-1:0] rshift;

  assign sh     = {lane_i, 3'b000};
  assign rshift = rdata_raw_i >> sh;

  always_comb begin
    unique case (size_i)
      3'd1: begin
        be_o    = 4'b0001 << lane_i;
        wdata_o = {24'b0, wdata_i[7:0]} << sh;
        rdata_o = {24'b0, rshift[7:0]};
      end
      3'd2: begin
        be_o    = 4'b0011 << lane_i;
        wdata_o = {16'b0, wdata_i[15:0]} << sh;
        rdata_o = {16'b0, rshift[15:0]};
      end
      default: begin
        be_o    = 4'b1111;
        wdata_o = wdata_i;
        rdata_o = rdata_raw_i;
      end
    endcase
  end
endmodule

// File: rtl/cfg_router.sv
module cfg_router
  import cfg_router_pkg::*;
#(
  parameter  int N_PORTS = 4,
  localparam int PORT_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [7:0]               req_bus_i,
  input  logic [7:0]               req_devfn_i,
  input  logic [11:0]              req_off_i,
  input  logic [2:0]               req_size_i,
  input  logic                     req_we_i,
  input  logic [31:0]              req_wdata_i,
  output logic                     rsp_valid_o,
  output logic [1:0]               rsp_status_o,
  output logic [31:0]              rsp_rdata_o,
  input  logic [N_PORTS*8-1:0]     port_devfn_i,
  input  logic [N_PORTS*8-1:0]     port_sec_bus_i,
  input  logic [N_PORTS*8-1:0]     port_sub_bus_i,
  input  logic [N_PORTS-1:0]       port_link_up_i,
  output logic                     dn_req_o,
  output logic                     dn_bridge_o,
  output logic [PORT_W-1:0]        dn_port_o,
  output logic                     dn_we_o,
  output logic [31:0]              dn_addr_o,
  output logic [3:0]               dn_be_o,
  output logic [31:0]              dn_wdata_o,
  input  logic                     dn_ack_i,
  input  logic [31:0]              dn_rdata_i
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RESP} state_e;

  state_e            state_q;
  cfg_target_e       sel_tgt;
  logic [PORT_W-1:0] sel_port;
  logic              accept;

  logic [7:0]        bus_q, devfn_q;
  logic [11:0]       off_q;
  logic [2:0]        size_q;
  logic              we_q, bridge_q;
  logic [PORT_W-1:0] port_q;
  logic [31:0]       wdata_q, rdata_q;
  cfg_status_e       status_q;
  logic [31:0]       rd_aligned;

  cfg_port_select #(.N_PORTS(N_PORTS), .PORT_W(PORT_W)) u_sel (
    .bus_i        (req_bus_i),
    .devfn_i      (req_devfn_i),
    .port_devfn_i (port_devfn_i),
    .sec_bus_i    (port_sec_bus_i),
    .sub_bus_i    (port_sub_bus_i),
    .link_up_i    (port_link_up_i),
    .port_o       (sel_port),
    .target_o     (sel_tgt)
  );

  cfg_addr_fmt u_fmt (
    .bus_i    (bus_q),
    .devfn_i  (devfn_q),
    .off_i    (off_q),
    .bridge_i (bridge_q),
    .addr_o   (dn_addr_o)
  );

  cfg_lane_align u_lane (
    .lane_i      (off_q[1:0]),
    .size_i      (size_q),
    .wdata_i     (wdata_q),
    .rdata_raw_i (dn_rdata_i),
    .be_o        (dn_be_o),
    .wdata_o     (dn_wdata_o),
    .rdata_o     (rd_aligned)
  );

  assign accept = req_valid_i && (state_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      bus_q    <= '0;
      devfn_q  <= '0;
      off_q    <= '0;
      size_q   <= 3'd4;
      we_q     <= 1'b0;
      bridge_q <= 1'b0;
      port_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      status_q <= ST_OK;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          bus_q    <= req_bus_i;
          devfn_q  <= req_devfn_i;
          off_q    <= req_off_i;
          size_q   <= req_size_i;
          we_q     <= req_we_i;
          wdata_q  <= req_wdata_i;
          port_q   <= sel_port;
          bridge_q <= sel_tgt == TGT_BRIDGE;
          // no-device outranks the size check
          if (sel_tgt == TGT_NONE) begin
            status_q <= ST_NODEV;
            rdata_q  <= '1;
            state_q  <= S_RESP;
          end else if (!size_legal(req_size_i)) begin
            status_q <= ST_BADREG;
            rdata_q  <= '1;
            state_q  <= S_RESP;
          end else begin
            state_q  <= S_WAIT;
          end
        end
        S_WAIT: if (dn_ack_i) begin
          status_q <= ST_OK;
          rdata_q  <= we_q ? '0 : rd_aligned;
          state_q  <= S_RESP;
        end
        S_RESP:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o  = state_q == S_IDLE;
  assign rsp_valid_o  = state_q == S_RESP;
  assign rsp_status_o = status_q;
  assign rsp_rdata_o  = rdata_q;
  assign dn_req_o     = state_q == S_WAIT;
  assign dn_bridge_o  = bridge_q;
  assign dn_port_o    = port_q;
  assign dn_we_o      = we_q;
endmodule

// File: rtl/cfg_router_chk.sv
module cfg_router_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic [1:0]  rsp_status_o,
  input logic [31:0] rsp_rdata_o,
  input logic        dn_req_o,
  input logic        dn_bridge_o,
  input logic [31:0] dn_addr_o,
  input logic [3:0]  dn_be_o,
  input logic        dn_ack_i
);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R9
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_req_o || rsp_valid_o) |-> !req_ready_o);
  // R9
  dn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_req_o && !dn_ack_i) |=> (dn_req_o && $stable(dn_addr_o) && $stable(dn_be_o)));
  // R2
  nodev_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'b01) |-> rsp_rdata_o == 32'hFFFF_FFFF);
  // R8
  badreg_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'b10) |-> rsp_rdata_o == 32'hFFFF_FFFF);
  // R5
  enable_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_req_o && !dn_bridge_o) |-> (dn_addr_o[31] && dn_addr_o[1:0] == 2'b00));
  // R7
  be_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> dn_be_o != 4'b0000);
endmodule

bind cfg_router cfg_router_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_status_o (rsp_status_o),
  .rsp_rdata_o  (rsp_rdata_o),
  .dn_req_o     (dn_req_o),
  .dn_bridge_o  (dn_bridge_o),
  .dn_addr_o    (dn_addr_o),
  .dn_be_o      (dn_be_o),
  .dn_ack_i     (dn_ack_i)
);

// File: tb/cfg_router_bench.sv
`timescale 1ns/1ps
module cfg_router_bench;
  localparam int NP = 4;

  typedef struct {
    logic [1:0]  st;
    logic [31:0] rd;
    logic        dn;
    logic        br;
    logic [1:0]  port;
    logic        we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    string       tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_we = 0;
  logic [7:0] req_bus = 0, req_devfn = 0;
  logic [11:0] req_off = 0;
  logic [2:0] req_size = 4;
  logic [31:0] req_wdata = 0;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic [31:0] rsp_rdata;
  logic [NP*8-1:0] p_devfn, p_sec, p_sub;
  logic [NP-1:0] p_link;
  logic dn_req, dn_bridge, dn_we, dn_ack = 0;
  logic [1:0] dn_port;
  logic [31:0] dn_addr, dn_wdata, dn_rdata = 0;
  logic [3:0] dn_be;

  logic [7:0] c_devfn[NP] = '{8'h00, 8'h08, 8'h10, 8'h08};
  logic [7:0] c_sec[NP]   = '{8'd1, 8'd4, 8'd5, 8'd2};
  logic [7:0] c_sub[NP]   = '{8'd3, 8'd4, 8'd9, 8'd6};
  logic       c_link[NP]  = '{1'b1, 1'b0, 1'b1, 1'b1};

  always_comb
    for (int i = 0; i < NP; i++) begin
      p_devfn[i*8 +: 8] = c_devfn[i];
      p_sec[i*8 +: 8]   = c_sec[i];
      p_sub[i*8 +: 8]   = c_sub[i];
      p_link[i]         = c_link[i];
    end

  always #10 clk = ~clk;

  cfg_router #(.N_PORTS(NP)) u_cfg_router (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bus_i(req_bus), .req_devfn_i(req_devfn), .req_off_i(req_off),
    .req_size_i(req_size), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_rdata_o(rsp_rdata),
    .port_devfn_i(p_devfn), .port_sec_bus_i(p_sec), .port_sub_bus_i(p_sub),
    .port_link_up_i(p_link),
    .dn_req_o(dn_req), .dn_bridge_o(dn_bridge), .dn_port_o(dn_port), .dn_we_o(dn_we),
    .dn_addr_o(dn_addr), .dn_be_o(dn_be), .dn_wdata_o(dn_wdata),
    .dn_ack_i(dn_ack), .dn_rdata_i(dn_rdata)
  );

  int checks = 0, errors = 0;
  exp_t rsp_q[$], dn_q[$];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return a ^ 32'hC3A5_5A3C;
  endfunction

  function automatic exp_t model(input logic [7:0] bus, input logic [7:0] devfn,
                                 input logic [11:0] off, input logic [2:0] size,
                                 input logic we, input logic [31:0] wd, input string tag);
    exp_t e;
    int sel = -1;
    logic [4:0] sh;
    e = '{st:2'b01, rd:32'hFFFF_FFFF, dn:0, br:0, port:0, we:we, addr:0, be:0, wd:0, tag:tag};
    for (int i = 0; i < NP; i++)
      if (sel < 0 && ((bus == 0 && c_devfn[i] == devfn) ||
                      (bus != 0 && bus >= c_sec[i] && bus <= c_sub[i]))) sel = i;
    if (sel < 0) return e;
    if (bus != 0 && !c_link[sel]) return e;
    if (bus != 0 && bus == c_sec[sel] && devfn[7:3] != 0) return e;
    if (!(size == 1 || size == 2 || size == 4)) begin
      e.st = 2'b10;
      return e;
    end
    e.st = 2'b00; e.dn = 1; e.br = (bus == 0); e.port = 2'(sel);
    e.addr = e.br ? {20'b0, off[11:2], 2'b00}
                  : {1'b1, 3'b0, off[11:8], bus, devfn, off[7:2], 2'b00};
    sh = {off[1:0], 3'b000};
    case (size)
      1: begin e.be = 4'b0001 << off[1:0]; e.wd = {24'b0, wd[7:0]} << sh;
               e.rd = (word_of(e.addr) >> sh) & 32'hFF; end
      2: begin e.be = 4'b0011 << off[1:0]; e.wd = {16'b0, wd[15:0]} << sh;
               e.rd = (word_of(e.addr) >> sh) & 32'hFFFF; end
      default: begin e.be = 4'hF; e.wd = wd; e.rd = word_of(e.addr); end
    endcase
    if (we) e.rd = 0;
    return e;
  endfunction

  task automatic send(input logic [7:0] bus, input logic [7:0] devfn, input logic [11:0] off,
                      input logic [2:0] size, input logic we, input logic [31:0] wd,
                      input string tag);
    exp_t e;
    e = model(bus, devfn, off, size, we, wd, tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rsp_q.push_back(e);
    if (e.dn) dn_q.push_back(e);
    req_valid = 1; req_bus = bus; req_devfn = devfn; req_off = off;
    req_size = size; req_we = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, {tag, " R9 busy after accept"}, 64'(req_ready), 64'd0);
  endtask

  // downstream responder with varying latency
  initial begin : responder
    int lat = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (dn_req && rst_n) begin
        if (dn_q.size() == 0) begin
          chk(0, "R8 unexpected downstream access", 64'(dn_addr), 64'd0);
        end else begin
          e = dn_q.pop_front();
          chk(dn_bridge == e.br && dn_port == e.port, {e.tag, " target"},
              64'({dn_bridge, dn_port}), 64'({e.br, e.port}));
          chk(dn_addr == e.addr, {e.tag, " R5 address"}, 64'(dn_addr), 64'(e.addr));
          chk(dn_we == e.we && dn_be == e.be && (!e.we || dn_wdata == e.wd), {e.tag, " R7 lanes"},
              64'({dn_we, dn_be, dn_wdata}), 64'({e.we, e.be, e.wd}));
        end
        repeat (lat) @(negedge clk);
        chk(dn_req == 1, "R9 request held", 64'(dn_req), 64'd1);
        lat = (lat + 1) % 4;
        dn_ack = 1; dn_rdata = word_of(dn_addr);
        @(negedge clk);
        dn_ack = 0; dn_rdata = 32'hDEAD_0000;
      end
    end
  end

  // response monitor
  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (rsp_valid && rst_n) begin
        if (rsp_q.size() == 0) chk(0, "R9 extra response", 64'(rsp_status), 64'd0);
        else begin
          e = rsp_q.pop_front();
          chk(rsp_status == e.st && rsp_rdata == e.rd, e.tag,
              64'({rsp_status, rsp_rdata}), 64'({e.st, e.rd}));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && dn_req == 0, "R10 reset state",
        64'({req_ready, rsp_valid, dn_req}), 64'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && dn_req == 0, "R10 after release",
        64'({req_ready, rsp_valid, dn_req}), 64'b100);

    send(8'd0,  8'h08, 12'h000, 3'd4, 0, 0,            "R1 bus0 duplicate devfn to port1 bridge");
    send(8'd0,  8'h10, 12'h01A, 3'd1, 1, 32'h5C,       "R1 bus0 byte write port2 bridge");
    send(8'd0,  8'h18, 12'h000, 3'd4, 0, 0,            "R1 bus0 unknown devfn");
    send(8'd2,  8'h28, 12'h104, 3'd4, 0, 0,            "R2 subordinate bus port0 link");
    send(8'd4,  8'h00, 12'h000, 3'd4, 0, 0,            "R3 link down on lowest match");
    send(8'd6,  8'h00, 12'hFFE, 3'd2, 0, 0,            "R2 overlap picks port2 R6 half read");
    send(8'd10, 8'h00, 12'h000, 3'd4, 1, 32'h1,        "R2 unmatched bus");
    send(8'd1,  8'h0B, 12'h000, 3'd4, 0, 0,            "R4 secondary bus device 1");
    send(8'd5,  8'h03, 12'h0C3, 3'd1, 0, 0,            "R4 secondary bus device 0 R6 byte lane3");
    send(8'd0,  8'h00, 12'h000, 3'd3, 0, 0,            "R8 bad size");
    send(8'd10, 8'h00, 12'h000, 3'd3, 0, 0,            "R8 no device outranks bad size");
    send(8'd1,  8'h00, 12'h012, 3'd2, 1, 32'hBEEF,     "R7 half write lane2");
    send(8'd0,  8'h00, 12'h001, 3'd2, 0, 0,            "R6 half read lane1 bridge");
    send(8'd2,  8'h00, 12'h003, 3'd4, 1, 32'h1234_5678, "R7 word write ignores lane");
    send(8'd3,  8'h00, 12'h023, 3'd2, 1, 32'hA1B2,     "R7 half write lane3 truncated");

    while (rsp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(dn_q.size() == 0, "R9 all downstream served", 64'(dn_q.size()), 64'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule